// File: doc/BRIEF.md
# Banked Interrupt Collector

This block gathers interrupt sources in groups of 32, one group per bank, and raises one request line per bank toward a processor's interrupt input. Each source latches into a pending bit when it rises. Software sees each bank as a small group of 32-bit registers on a simple byte-addressed read/write bus. Through them it clears pending bits, chooses which sources may request service, and inhibits a bank's request through a mask. It can also force pending bits, so that an interrupt is taken again.

Software reads the bank's pending-and-enabled view to find out which source needs attention. It clears that source by writing a one to its pending bit, and it enables or disables a source with a read-modify-write of the enable register. The bank count is a parameter. Banks sit back to back at a fixed stride of 40 bytes.

Top module: `irqu_top`

## Requirements
- R1: Bank n occupies byte addresses n*40 to n*40+39. Inside a bank, the pending register is at offset 0, the enable register at 8, the pending-and-enabled view at 16, the resend register at 24 and the mask register at 32. Source bit i of bank n is `src_in[n*32+i]` and maps to bit i of each register.
- R2: A 0-to-1 transition of a source, seen at a clock edge, sets its pending bit at that edge. A source that stays high does not set the bit again after software has cleared it.
- R3: Writing the pending register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a source sets a pending bit in the same cycle as a write that clears it, the bit ends up set.
- R5: The enable register holds the last value written to it and reads it back.
- R6: The view at offset 16 reads as pending AND enable. Writes to that offset change nothing.
- R7: Writing the resend register sets every pending bit written as 1. The resend register always reads as zero.
- R8: `irq_out[n]` is 1 one cycle after bank n has at least one bit that is pending, enabled and has a mask bit of 0. A mask bit of 1 blocks that source from the request.
- R9: After reset, the pending and enable registers are zero, the mask register is all ones and every `irq_out` is 0.
- R10: Offsets inside a bank other than the five listed, and addresses at or beyond the last bank, read as zero. Writes to them change no register.
- R11: `bus_rdata` shows the addressed value in the cycle after a read is presented. In a cycle with no read presented, it is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | NUM_BANKS*32 | Interrupt sources, bank-major |
| irq_out | output | NUM_BANKS | Per-bank request line |

## Verification
The bench sweeps every byte address of every bank and the whole space beyond the last bank. This exposes a wrong stride or a wrong offset decode, which would show up as a mask value at the wrong address or as data at a hole. It walks every source bit of every bank through the set and clear steps. A swapped or stuck bit, or a bank cross-wired to another bank, would read back a wrong pending pattern. The bench also collides a rising edge with a clear write, where a design that lets the clear win would lose the interrupt. It holds a source high across a clear, where a level-sensitive design would set the bit again. Finally it steps the mask and enable registers around a live pending bit, where a design that ignores the mask, or has no output register, would raise or drop `irq_out` in the wrong cycle.

// File: rtl/irqu_pkg.sv
`timescale 1ns/1ps
package irqu_pkg;
  localparam int unsigned SRC_W       = 32;
  localparam int unsigned BANK_STRIDE = 40;
  localparam int unsigned OFF_W       = $clog2(BANK_STRIDE);

  typedef logic [SRC_W-1:0] src_vec_t;

  typedef enum logic [2:0] {
    RK_NONE, RK_STAT, RK_EN, RK_ESTAT, RK_RESEND, RK_MASK
  } reg_kind_e;

  // Offset inside a bank to register kind; holes map to RK_NONE.
  function automatic reg_kind_e kind_of(input logic [OFF_W-1:0] off);
    case (off)
      OFF_W'(0):  kind_of = RK_STAT;
      OFF_W'(8):  kind_of = RK_EN;
      OFF_W'(16): kind_of = RK_ESTAT;
      OFF_W'(24): kind_of = RK_RESEND;
      OFF_W'(32): kind_of = RK_MASK;
      default:    kind_of = RK_NONE;
    endcase
  endfunction

  // Set beats clear when both hit one bit in the same cycle.
  function automatic src_vec_t next_pending(input src_vec_t cur,
                                            input src_vec_t clr,
                                            input src_vec_t set);
    next_pending = (cur & ~clr) | set;
  endfunction

  function automatic logic bank_request(input src_vec_t pend,
                                        input src_vec_t en,
                                        input src_vec_t inhibit);
    bank_request = |(pend & en & ~inhibit);
  endfunction
endpackage

// File: rtl/irqu_decode.sv
`timescale 1ns/1ps
module irqu_decode
  import irqu_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_sel,
  output reg_kind_e            kind
);
  localparam int unsigned SPAN = NUM_BANKS * BANK_STRIDE;

  logic [ADDR_W-1:0] idx;
  logic [OFF_W-1:0]  off;
  logic              in_range;

  always_comb begin
    idx      = addr / ADDR_W'(BANK_STRIDE);
    off      = OFF_W'(addr % ADDR_W'(BANK_STRIDE));
    in_range = 32'(addr) < SPAN;
    kind     = in_range ? kind_of(off) : RK_NONE;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign bank_sel[b] = in_range && (idx == ADDR_W'(b));
  end
endmodule

// File: rtl/irqu_edge.sv
`timescale 1ns/1ps
module irqu_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/irqu_bank.sv
`timescale 1ns/1ps
module irqu_bank
  import irqu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      wr,
  input  reg_kind_e kind,
  input  src_vec_t  wdata,
  input  src_vec_t  src_rise,
  output src_vec_t  rd_val,
  output logic      irq
);
  src_vec_t pending, enable, inhibit;
  src_vec_t clr_vec, resend_vec, set_vec;
  logic     wr_hit, en_wr, mask_wr;

  assign wr_hit     = sel && wr;
  assign clr_vec    = (wr_hit && kind == RK_STAT)   ? wdata : '0;
  assign resend_vec = (wr_hit && kind == RK_RESEND) ? wdata : '0;
  assign en_wr      = wr_hit && kind == RK_EN;
  assign mask_wr    = wr_hit && kind == RK_MASK;
  assign set_vec    = src_rise | resend_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      enable  <= '0;
      inhibit <= '1;
      irq     <= 1'b0;
    end else begin
      pending <= next_pending(pending, clr_vec, set_vec);
      if (en_wr)   enable  <= wdata;
      if (mask_wr) inhibit <= wdata;
      irq <= bank_request(pending, enable, inhibit);
    end
  end

  always_comb begin
    case (kind)
      RK_STAT:  rd_val = pending;
      RK_EN:    rd_val = enable;
      RK_ESTAT: rd_val = pending & enable;
      RK_MASK:  rd_val = inhibit;
      default:  rd_val = '0;
    endcase
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pending & $past(set_vec)) == $past(set_vec)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((pending & $past(clr_vec & ~set_vec)) == '0));

  // R5
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (enable == $past(wdata)));

  // R8
  req_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(pending) != '0));

  // R8
  full_mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&inhibit) |=> !irq);
endmodule

// File: rtl/irqu_top.sv
`timescale 1ns/1ps
module irqu_top
  import irqu_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [SRC_W-1:0]           bus_wdata,
  output logic [SRC_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*SRC_W-1:0] src_in,
  output logic [NUM_BANKS-1:0]       irq_out
);
  localparam int unsigned TOTAL_SRC = NUM_BANKS * SRC_W;

  logic [NUM_BANKS-1:0] bank_sel;
  reg_kind_e            kind;
  logic [TOTAL_SRC-1:0] rise_all;
  src_vec_t             bank_rd [NUM_BANKS];
  src_vec_t             rd_mux;

  irqu_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .bank_sel(bank_sel), .kind(kind)
  );

  irqu_edge #(.W(TOTAL_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(src_in), .rise(rise_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqu_bank u_bank (
      .clk(clk), .rst_n(rst_n), .sel(bank_sel[b]), .wr(bus_wr),
      .kind(kind), .wdata(bus_wdata),
      .src_rise(rise_all[b*SRC_W +: SRC_W]),
      .rd_val(bank_rd[b]), .irq(irq_out[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel[b]) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // R10
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/irqu_top_test.sv
`timescale 1ns/1ps
module irqu_top_test;
  localparam int NB = 4;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NB*32-1:0] src_in = '0;
  logic [NB-1:0]  irq_out;

  int errors = 0;
  int checks = 0;

  irqu_top #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] at(input int bank, input int off);
    return AW'(bank * 40 + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); src_in[idx] = 1'b1;
    @(negedge clk); src_in[idx] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state of request lines
    check("R9 irq_out after reset", 32'(irq_out), 32'h0);
    // R1 R9 R10 full address sweep after reset
    for (int a = 0; a < 256; a++) begin
      rd(AW'(a), v);
      if (a < NB * 40 && (a % 40) == 32) check("R9 mask reset / R1 map", v, 32'hFFFF_FFFF);
      else check("R10 R9 zero read", v, 32'h0);
    end
    // R11 idle cycle gives zero
    @(negedge clk);
    check("R11 idle rdata", bus_rdata, 32'h0);
    // R1 R2 R3 walk each bit of each bank
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < 32; i++) begin
        pulse(b * 32 + i);
        rd(at(b, 0), v);
        check("R2 R1 pending bit set", v, 32'h1 << i);
        wr(at(b, 0), 32'h0);
        rd(at(b, 0), v);
        check("R3 zero write keeps", v, 32'h1 << i);
        wr(at(b, 0), 32'h1 << i);
        rd(at(b, 0), v);
        check("R3 one write clears", v, 32'h0);
      end
    end
    // R4 set and clear collide
    @(negedge clk);
    src_in[32 + 5] = 1'b1; bus_wr = 1'b1; bus_addr = at(1, 0); bus_wdata = 32'h20;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(at(1, 0), v);
    check("R4 set wins", v, 32'h20);
    // R2 held-high source does not set again after clear
    wr(at(1, 0), 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd(at(1, 0), v);
    check("R2 level held no reset", v, 32'h0);
    src_in[32 + 5] = 1'b0;
    // R7 resend
    wr(at(2, 24), 32'h0000_00A5);
    rd(at(2, 0), v);
    check("R7 resend sets pending", v, 32'h0000_00A5);
    rd(at(2, 24), v);
    check("R7 resend reads zero", v, 32'h0);
    wr(at(2, 0), 32'hFFFF_FFFF);
    // R5 R6 enable and view
    wr(at(3, 8), 32'h0000_00F0);
    rd(at(3, 8), v);
    check("R5 enable readback", v, 32'h0000_00F0);
    wr(at(3, 24), 32'h0000_00FF);
    rd(at(3, 16), v);
    check("R6 pending and enable", v, 32'h0000_00F0);
    wr(at(3, 16), 32'hFFFF_FFFF);
    rd(at(3, 8), v);
    check("R6 view write ignored enable", v, 32'h0000_00F0);
    rd(at(3, 0), v);
    check("R6 view write ignored pending", v, 32'h0000_00FF);
    // R10 hole and out-of-range writes ignored
    wr(at(3, 4), 32'hFFFF_FFFF);
    wr(at(3, 12), 32'h0);
    wr(at(3, 36), 32'h0);
    wr(AW'(NB * 40), 32'h0);
    rd(at(3, 8), v);
    check("R10 enable untouched", v, 32'h0000_00F0);
    rd(at(3, 32), v);
    check("R10 mask untouched", v, 32'hFFFF_FFFF);
    rd(at(3, 0), v);
    check("R10 pending untouched", v, 32'h0000_00FF);
    // R8 request gating
    check("R8 full mask blocks", 32'(irq_out), 32'h0);
    wr(at(3, 32), 32'hFFFF_FFEF);
    @(negedge clk);
    check("R8 unmasked request", 32'(irq_out), 32'h8);
    wr(at(3, 8), 32'h0000_0020);
    check("R8 request one cycle after disable", 32'(irq_out), 32'h8);
    @(negedge clk);
    check("R8 disabled drops request", 32'(irq_out), 32'h0);
    wr(at(3, 8), 32'h0000_0010);
    @(negedge clk);
    check("R8 re-enabled request", 32'(irq_out), 32'h8);
    wr(at(3, 0), 32'h0000_0010);
    @(negedge clk);
    check("R8 clear drops request", 32'(irq_out), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule